// File: doc/BRIEF.md
# Bit-Serial Pixel Processing Element

This block is one cell of a pixel-parallel array processor. All cells receive the same 22-bit microword every clock cycle. Each cell applies that microword to its own one-bit state: an accumulator, a carry bit, three general bits, a mask bit, a neighbour-output bit and a 256-entry one-bit scratch memory. One operation completes per cycle. The result of that operation reaches its destinations at the next rising edge.

Each cycle, a one-bit operand is chosen from local storage or from one of four neighbour inputs. That operand meets the accumulator and the carry in an eight-function ALU. The ALU can invert the accumulator on its way in and can invert the result on its way out. The result always loads the accumulator, and it can also be routed to a general bit, the memory, the mask bit or the neighbour-output bit.

When the mask bit is clear, the cell is idle: its general bits, memory and neighbour-output bit are frozen. Its accumulator and carry keep working, and the mask bit itself can still be loaded. The microword and neighbour bits are plain per-cycle control with no handshake. The cell never stalls and applies no back-pressure.

Top module: `pxl_pe`

## Requirements
- R1: After reset the accumulator, carry, X, Y, Z and neighbour-output bit are 0 and the mask bit is 1.
- R2: Microword fields, MSB first: address[21:14], mem_wr[13], src[12:10], fn[9:7], acc_inv[6], res_inv[5], dst[4:3], nout_ld[2], mask_ld[1], carry_clr[0].
- R3: src selects the ALU operand: 0 memory bit at the address, 1 X, 2 Y, 3 Z, 4 north, 5 east, 6 west, 7 south.
- R4: fn selects 0 operand, 1 operand AND acc, 2 operand XOR acc, 3 operand OR acc, 4 full-adder sum of operand, acc and carry, 5 full-adder carry-out of the same three, 6 constant 0, 7 constant 1. The accumulator is loaded with the result at every edge.
- R5: acc_inv=1 feeds the inverted accumulator to the ALU, and res_inv=1 inverts the ALU result before it is stored anywhere.
- R6: The carry bit takes the full-adder carry-out only when fn=4 and otherwise keeps its value.
- R7: carry_clr=1 zeroes the carry bit and takes priority over fn=4.
- R8: dst 1, 2 and 3 load the result into X, Y and Z respectively, and dst 0 loads none of them.
- R9: While the mask bit is 0, X, Y, Z, the memory and the neighbour-output bit do not change, while the accumulator and carry still update.
- R10: mask_ld=1 loads the result into the mask bit, even while the mask bit is 0.
- R11: A cycle with mem_wr=1 reads the old bit at the address as operand and writes the result there at the edge. A later read of that address returns the new bit.
- R12: nout_ld=1 loads the result into the neighbour-output bit (port nout); with nout_ld=0 it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| uword | input | 22 | Broadcast microword |
| nb_n | input | 1 | North neighbour bit |
| nb_e | input | 1 | East neighbour bit |
| nb_w | input | 1 | West neighbour bit |
| nb_s | input | 1 | South neighbour bit |
| nout | output | 1 | Neighbour-output bit |
| acc_o | output | 1 | Accumulator view |
| carry_o | output | 1 | Carry view |
| mask_o | output | 1 | Mask bit view |
| x_o | output | 1 | X view |
| y_o | output | 1 | Y view |
| z_o | output | 1 | Z view |

## Verification
Every result is due exactly one rising edge after its microword is presented. The operand path, including the memory read, is combinational within the cycle, and all state loads at that one edge. The bench drives a microword just after an edge and samples all views just after the following edge, one microword per cycle. The memory contents are observed only through the accumulator: a later microword copies the stored bit into it, and that value is checked one edge after the copy.

// File: rtl/pxl_pe_pkg.sv
package pxl_pe_pkg;
  localparam int MEM_AW = 8;
  localparam int UW_W   = MEM_AW + 14;

  typedef enum logic [2:0] {
    SRC_MEM = 3'd0, SRC_X = 3'd1, SRC_Y = 3'd2, SRC_Z = 3'd3,
    SRC_N   = 3'd4, SRC_E = 3'd5, SRC_W = 3'd6, SRC_S = 3'd7
  } src_e;

  typedef enum logic [2:0] {
    FN_PASS = 3'd0, FN_AND = 3'd1, FN_XOR = 3'd2, FN_OR  = 3'd3,
    FN_SUM  = 3'd4, FN_CY  = 3'd5, FN_LO  = 3'd6, FN_HI  = 3'd7
  } fn_e;

  typedef struct packed {
    logic [MEM_AW-1:0] addr;
    logic              mem_wr;
    src_e              src;
    fn_e               fn;
    logic              acc_inv;
    logic              res_inv;
    logic [1:0]        dst;
    logic              nout_ld;
    logic              mask_ld;
    logic              carry_clr;
  } uword_t;
endpackage

// File: rtl/pxl_pe_mem.sv
module pxl_pe_mem #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          wbit,
  output logic          rbit
);
  localparam int DEPTH = 1 << AW;

  logic store [DEPTH];

  // Read is combinational so read and write-back share one cycle.
  assign rbit = store[addr];

  always_ff @(posedge clk) begin
    if (wr) store[addr] <= wbit;
  end
endmodule

// File: rtl/pxl_pe_opsel.sv
module pxl_pe_opsel
  import pxl_pe_pkg::*;
(
  input  src_e sel,
  input  logic mem_bit,
  input  logic [2:0] gp,
  input  logic [3:0] nbr,   // {n, e, w, s}
  output logic opnd
);
  logic [7:0] cand;

  always_comb begin
    cand = {nbr[0], nbr[1], nbr[2], nbr[3], gp[2], gp[1], gp[0], mem_bit};
    opnd = cand[sel];
  end
endmodule

// File: rtl/pxl_pe_alu.sv
module pxl_pe_alu
  import pxl_pe_pkg::*;
(
  input  fn_e  fn,
  input  logic opnd,
  input  logic acc,
  input  logic cin,
  input  logic acc_inv,
  input  logic res_inv,
  output logic res,
  output logic cout
);
  logic a_eff;
  logic raw;

  always_comb begin
    a_eff = acc ^ acc_inv;
    cout  = (opnd & a_eff) | (opnd & cin) | (a_eff & cin);
    unique case (fn)
      FN_PASS: raw = opnd;
      FN_AND:  raw = opnd & a_eff;
      FN_XOR:  raw = opnd ^ a_eff;
      FN_OR:   raw = opnd | a_eff;
      FN_SUM:  raw = opnd ^ a_eff ^ cin;
      FN_CY:   raw = cout;
      FN_LO:   raw = 1'b0;
      default: raw = 1'b1;
    endcase
    res = raw ^ res_inv;
  end
endmodule

// File: rtl/pxl_pe.sv
module pxl_pe
  import pxl_pe_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [UW_W-1:0] uword,
  input  logic            nb_n,
  input  logic            nb_e,
  input  logic            nb_w,
  input  logic            nb_s,
  output logic            nout,
  output logic            acc_o,
  output logic            carry_o,
  output logic            mask_o,
  output logic            x_o,
  output logic            y_o,
  output logic            z_o
);
  localparam int NGP = 3;

  uword_t     uw;
  logic       acc_q, carry_q, mask_q, nout_q;
  logic [NGP-1:0] gp;
  logic       mem_bit, opnd, res, cout;

  assign uw = uword_t'(uword);

  pxl_pe_mem #(.AW(MEM_AW)) u_mem (
    .clk  (clk),
    .addr (uw.addr),
    .wr   (uw.mem_wr & mask_q),
    .wbit (res),
    .rbit (mem_bit)
  );

  pxl_pe_opsel u_sel (
    .sel     (uw.src),
    .mem_bit (mem_bit),
    .gp      (gp),
    .nbr     ({nb_n, nb_e, nb_w, nb_s}),
    .opnd    (opnd)
  );

  pxl_pe_alu u_alu (
    .fn      (uw.fn),
    .opnd    (opnd),
    .acc     (acc_q),
    .cin     (carry_q),
    .acc_inv (uw.acc_inv),
    .res_inv (uw.res_inv),
    .res     (res),
    .cout    (cout)
  );

  // General bits: destination code g+1 selects entry g.
  for (genvar g = 0; g < NGP; g++) begin : g_gp
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   q <= 1'b0;
      else if (mask_q && uw.dst == 2'(g + 1))       q <= res;
    end
    assign gp[g] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= 1'b0;
      carry_q <= 1'b0;
      mask_q  <= 1'b1;
      nout_q  <= 1'b0;
    end else begin
      acc_q <= res;
      if (uw.carry_clr)          carry_q <= 1'b0;
      else if (uw.fn == FN_SUM)  carry_q <= cout;
      if (uw.mask_ld)            mask_q  <= res;
      if (uw.nout_ld && mask_q)  nout_q  <= res;
    end
  end

  assign nout    = nout_q;
  assign acc_o   = acc_q;
  assign carry_o = carry_q;
  assign mask_o  = mask_q;
  assign x_o     = gp[0];
  assign y_o     = gp[1];
  assign z_o     = gp[2];

  AST_ACC_SET1: assert property (@(posedge clk) disable iff (!rst_n)
    (uw.fn == FN_HI && !uw.res_inv) |=> acc_o);  // R4
  AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (uw.fn != FN_SUM && !uw.carry_clr) |=> $stable(carry_o));  // R6
  AST_CARRY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    uw.carry_clr |=> !carry_o);  // R7
  AST_DST_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (uw.dst == 2'd0) |=> $stable({x_o, y_o, z_o}));  // R8
  AST_MASK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_o |=> $stable({x_o, y_o, z_o, nout}));  // R9
  AST_NOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !uw.nout_ld |=> $stable(nout));  // R12
endmodule

// File: tb/pxl_pe_tb.sv
module pxl_pe_tb_top;
  localparam int NV = 34;
  localparam logic [2:0] S_M = 3'd0, S_X = 3'd1, S_Y = 3'd2, S_Z = 3'd3,
                         S_N = 3'd4, S_E = 3'd5, S_W = 3'd6, S_S = 3'd7;
  localparam logic [2:0] F_P = 3'd0, F_AND = 3'd1, F_XOR = 3'd2, F_OR = 3'd3,
                         F_SUM = 3'd4, F_CY = 3'd5, F_0 = 3'd6, F_1 = 3'd7;

  function automatic logic [21:0] mk(input logic [7:0] a, input logic we,
      input logic [2:0] sel, input logic [2:0] op, input logic ia,
      input logic io, input logic [1:0] dst, input logic ne,
      input logic fe, input logic cc);
    return {a, we, sel, op, ia, io, dst, ne, fe, cc};  // R2 layout
  endfunction

  function automatic logic [27:0] row(input logic [21:0] u, input logic [3:0] nb,
      input logic ea, input logic ec);
    return {u, nb, ea, ec};
  endfunction

  // {microword, {n,e,w,s}, expected acc, expected carry}
  localparam logic [27:0] VEC [NV] = '{
    row(mk(0,0,S_N,F_P  ,0,0,0,0,0,0), 4'b1000, 1, 0),
    row(mk(0,0,S_E,F_AND,0,0,0,0,0,0), 4'b0100, 1, 0),
    row(mk(0,0,S_W,F_XOR,0,0,0,0,0,0), 4'b0010, 0, 0),
    row(mk(0,0,S_S,F_OR ,0,0,0,0,0,0), 4'b0001, 1, 0),
    row(mk(0,0,S_N,F_0  ,0,0,0,0,0,0), 4'b0000, 0, 0),
    row(mk(0,0,S_N,F_1  ,0,0,0,0,0,0), 4'b0000, 1, 0),
    row(mk(0,0,S_N,F_SUM,0,0,0,0,0,0), 4'b1000, 0, 1),
    row(mk(0,0,S_N,F_P  ,0,0,0,0,0,0), 4'b0000, 0, 1),
    row(mk(0,0,S_N,F_CY ,0,0,0,0,0,0), 4'b1000, 1, 1),
    row(mk(0,0,S_N,F_SUM,0,0,0,0,0,1), 4'b1000, 1, 0),
    row(mk(0,0,S_N,F_SUM,0,0,0,0,0,0), 4'b1000, 0, 1),
    row(mk(0,0,S_N,F_P  ,0,0,0,0,0,1), 4'b0000, 0, 0),
    row(mk(0,0,S_N,F_P  ,0,1,0,0,0,0), 4'b0000, 1, 0),
    row(mk(0,0,S_N,F_AND,1,0,0,0,0,0), 4'b1000, 0, 0),
    row(mk(0,0,S_N,F_OR ,1,1,0,0,0,0), 4'b0000, 0, 0),
    row(mk(0,0,S_N,F_XOR,0,1,0,0,0,0), 4'b0000, 1, 0),
    row(mk(0,0,S_N,F_AND,0,1,0,0,0,0), 4'b1000, 0, 0),
    row(mk(0,0,S_N,F_1  ,0,0,1,0,0,0), 4'b0000, 1, 0),
    row(mk(0,0,S_N,F_0  ,0,0,2,0,0,0), 4'b0000, 0, 0),
    row(mk(0,0,S_X,F_P  ,0,0,0,0,0,0), 4'b0000, 1, 0),
    row(mk(0,0,S_N,F_1  ,0,0,3,0,0,0), 4'b0000, 1, 0),
    row(mk(0,0,S_N,F_0  ,0,0,0,0,0,0), 4'b0000, 0, 0),
    row(mk(0,0,S_Z,F_P  ,0,0,0,0,0,0), 4'b0000, 1, 0),
    row(mk(0,0,S_Y,F_P  ,0,0,0,0,0,0), 4'b0000, 0, 0),
    row(mk(8'h5A,1,S_M,F_1,0,0,0,0,0,0), 4'b0000, 1, 0),
    row(mk(8'hA5,1,S_M,F_0,0,0,0,0,0,0), 4'b0000, 0, 0),
    row(mk(8'h5A,1,S_M,F_P,0,1,0,0,0,0), 4'b0000, 0, 0),
    row(mk(8'h5A,0,S_M,F_P,0,0,0,0,0,0), 4'b0000, 0, 0),
    row(mk(8'hA5,1,S_M,F_P,0,1,0,0,0,0), 4'b0000, 1, 0),
    row(mk(8'hA5,0,S_M,F_P,0,0,0,0,0,0), 4'b0000, 1, 0),
    row(mk(8'hA5,0,S_M,F_P,0,0,1,0,0,0), 4'b0000, 1, 0),
    row(mk(8'h5A,1,S_X,F_P,0,0,0,0,0,0), 4'b0000, 1, 0),
    row(mk(0,0,S_N,F_0  ,0,0,0,0,0,0), 4'b0000, 0, 0),
    row(mk(8'h5A,0,S_M,F_P,0,0,0,0,0,0), 4'b0000, 1, 0)
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [21:0] uword = '0;
  logic nb_n = 0, nb_e = 0, nb_w = 0, nb_s = 0;
  logic nout, acc_o, carry_o, mask_o, x_o, y_o, z_o;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pxl_pe dut_i (
    .clk(clk), .rst_n(rst_n), .uword(uword),
    .nb_n(nb_n), .nb_e(nb_e), .nb_w(nb_w), .nb_s(nb_s),
    .nout(nout), .acc_o(acc_o), .carry_o(carry_o), .mask_o(mask_o),
    .x_o(x_o), .y_o(y_o), .z_o(z_o)
  );

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  // Drive just after an edge, sample just after the next one.
  task automatic step(input logic [21:0] u, input logic [3:0] nb);
    uword = u;
    {nb_n, nb_e, nb_w, nb_s} = nb;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(acc_o, 0, "R1", "acc after reset");
    chk(carry_o, 0, "R1", "carry after reset");
    chk(mask_o, 1, "R1", "mask after reset");
    chk(nout, 0, "R1", "nout after reset");
    chk(x_o | y_o | z_o, 0, "R1", "general bits after reset");
    rst_n = 1'b1;

    // Table walk: R2 R3 R4 R5 R6 R7 R8 R11
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][27:6], VEC[i][5:2]);
      chk(acc_o, VEC[i][1], "R3/R4/R5/R8/R11 table", $sformatf("acc row %0d", i));
      chk(carry_o, VEC[i][0], "R6/R7 table", $sformatf("carry row %0d", i));
    end
    chk(x_o, 1, "R8", "X after table");
    chk(z_o, 1, "R8", "Z after table");

    step(mk(0,0,S_N,F_1,0,0,0,1,0,0), 4'b0000);
    chk(nout, 1, "R12", "nout loaded");
    step(mk(0,0,S_N,F_0,0,0,0,0,0,0), 4'b0000);
    chk(nout, 1, "R12", "nout held without load");

    step(mk(0,0,S_N,F_0,0,0,0,0,1,0), 4'b0000);
    chk(mask_o, 0, "R10", "mask cleared");
    step(mk(8'h5A,1,S_N,F_0,0,0,1,1,0,0), 4'b0000);
    chk(x_o, 1, "R9", "X frozen while masked");
    chk(nout, 1, "R9", "nout frozen while masked");
    chk(acc_o, 0, "R9", "acc updates while masked");
    step(mk(0,0,S_N,F_SUM,0,0,0,0,0,0), 4'b1000);
    chk(acc_o, 1, "R9", "masked sum acc");
    step(mk(0,0,S_N,F_SUM,0,0,0,0,0,0), 4'b1000);
    chk(carry_o, 1, "R9", "carry updates while masked");
    step(mk(0,0,S_N,F_1,0,0,0,0,1,0), 4'b0000);
    chk(mask_o, 1, "R10", "mask reloaded while masked");
    step(mk(8'h5A,0,S_M,F_P,0,0,0,0,0,0), 4'b0000);
    chk(acc_o, 1, "R9", "memory bit frozen while masked");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule